// File: doc/BRIEF.md
# Peripheral Interrupt Status Flags with Two-Step Clear

This block holds the interrupt status flags of a peripheral and turns them into one interrupt request line. Each flag is set by a one-cycle hardware event pulse and stays set until software clears it. A flag raises the request only while its enable bit is set and the global interrupt mask input is low. A flag that is disabled or masked is not lost: it stays pending and raises the request as soon as both conditions allow it.

Software reaches the block over a small register bus. The bus has read and write strobes, a two-bit address, write data and combinational read data. The status register is at address 0, the enable (control) register at address 1 and the peripheral data register at address 2. There are two ways to clear a flag. The first is to write 0 to its status bit. The second is a sequence: read the status register while the flag is set, then read or write the data register. The sequence clears the flag whether or not it was enabled, so a request that was waiting behind the mask is dropped.

Top module: `irqFlagUnit`

## Requirements
- R1: After reset, reads of status (address 0), control (address 1) and data (address 2) return 0, and irq is low.
- R2: A high bit i of hwEvent in a cycle makes status bit i read 1 from the next cycle on. Status bits at and above FLAG_W read 0.
- R3: irq is high exactly when some status bit i and control bit i are both 1 and globalMask is low. irq follows state and globalMask in the same cycle.
- R4: A flag that is disabled or masked stays set. irq rises once its control bit is set and globalMask is low.
- R5: A status write with bit i = 0 clears flag i. A status write with bit i = 1 leaves flag i unchanged.
- R6: A flag that was 1 when the status register was read is cleared by the next data-register access, read or write.
- R7: A flag that was 0 at the last status read, and was set after it, survives the following data access.
- R8: The clear sequence discards a masked pending flag: after it, clearing globalMask does not raise irq.
- R9: A hardware event in the same cycle as either kind of clear leaves that flag set.
- R10: Every data access disarms the sequence. A flag set after one data access is not cleared by a second data access unless a new status read comes first.
- R11: A data-register write stores busWdata, and a data-register read returns the value stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busAddr | input | 2 | Register address: 0 status, 1 control, 2 data |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Read data; 0 when no read |
| hwEvent | input | FLAG_W | Per-flag set pulses from the peripheral |
| globalMask | input | 1 | Global interrupt mask; high blocks irq |
| irq | output | 1 | Interrupt request |

## Verification
The hardest state to reach from the ports is the armed state. It is invisible: it only exists between a status read and a later data access, and only shows in what that access clears. The bench sweeps every pair made of the flags set before the status read and the flags set between the read and the data access. It alternates data reads and data writes as the trigger and puts a shifted event pattern in the clearing cycle itself. The expected status is then computed as ((a|b)&~a)|c. A second sweep covers all 16x16 flag and enable patterns under both mask values.

// File: rtl/irqFlagPkg.sv
package irqFlagPkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_DATA   = 2'd2;

  typedef enum logic [1:0] {SEL_NONE, SEL_STATUS, SEL_CTRL, SEL_DATA} rdSel_e;

  typedef struct packed {
    logic   statusRd;
    logic   statusWr;
    logic   ctrlWr;
    logic   dataWr;
    logic   dataAccess;
    rdSel_e rdSel;
  } regStrobe_t;
endpackage

// File: rtl/irqFlagBusCtrl.sv
module irqFlagBusCtrl
  import irqFlagPkg::*;
(
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  output regStrobe_t        strobe
);
  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_NONE;
    unique case (busAddr)
      ADDR_STATUS: begin
        strobe.statusRd = busRd;
        strobe.statusWr = busWr;
        if (busRd) strobe.rdSel = SEL_STATUS;
      end
      ADDR_CTRL: begin
        strobe.ctrlWr = busWr;
        if (busRd) strobe.rdSel = SEL_CTRL;
      end
      ADDR_DATA: begin
        strobe.dataWr     = busWr;
        strobe.dataAccess = busRd | busWr;
        if (busRd) strobe.rdSel = SEL_DATA;
      end
      default: strobe.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/irqFlagCell.sv
module irqFlagCell (
  input  logic clk,
  input  logic rstN,
  input  logic hwSet,
  input  logic swWrite,
  input  logic swBit,
  input  logic statusRead,
  input  logic dataAccess,
  output logic flag,
  output logic armed
);
  logic flagNext;
  logic armedNext;

  always_comb begin
    flagNext = flag;
    if (swWrite && !swBit) flagNext = 1'b0;
    if (dataAccess && armed) flagNext = 1'b0;
    if (hwSet) flagNext = 1'b1;
  end

  always_comb begin
    armedNext = armed;
    if (dataAccess) armedNext = 1'b0;
    else if (statusRead) armedNext = flag;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      flag  <= flagNext;
      armed <= armedNext;
    end
  end

  p_event_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    hwSet |=> flag);
  p_write_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (swWrite && swBit && !dataAccess && !hwSet) |=> (flag == $past(flag)));
  p_write_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (swWrite && !swBit && !hwSet) |=> !flag);
  p_seq_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataAccess && armed && !hwSet) |=> !flag);
  p_disarm_r10: assert property (@(posedge clk) disable iff (!rstN)
    dataAccess |=> !armed);
  p_no_arm_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (statusRead && !flag && !dataAccess) |=> !armed);
endmodule

// File: rtl/irqFlagDatapath.sv
module irqFlagDatapath
  import irqFlagPkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strobe,
  input  logic [DATA_W-1:0] wdata,
  input  logic [FLAG_W-1:0] hwEvent,
  input  logic              globalMask,
  output logic [DATA_W-1:0] rdata,
  output logic              irq
);
  logic [FLAG_W-1:0] flags;
  logic [FLAG_W-1:0] armedVec;
  logic [FLAG_W-1:0] enReg;
  logic [DATA_W-1:0] dataReg;

  for (genvar i = 0; i < FLAG_W; i++) begin : gCell
    irqFlagCell uCell (
      .clk        (clk),
      .rstN       (rstN),
      .hwSet      (hwEvent[i]),
      .swWrite    (strobe.statusWr),
      .swBit      (wdata[i]),
      .statusRead (strobe.statusRd),
      .dataAccess (strobe.dataAccess),
      .flag       (flags[i]),
      .armed      (armedVec[i])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      dataReg <= '0;
    end else begin
      if (strobe.ctrlWr) enReg <= wdata[FLAG_W-1:0];
      if (strobe.dataWr) dataReg <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (strobe.rdSel)
      SEL_STATUS: rdata[FLAG_W-1:0] = flags;
      SEL_CTRL:   rdata[FLAG_W-1:0] = enReg;
      SEL_DATA:   rdata = dataReg;
      default:    rdata = '0;
    endcase
  end

  assign irq = (|(flags & enReg)) & ~globalMask;

  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rstN)
    globalMask |-> !irq);
  p_pending_kept_r4: assert property (@(posedge clk) disable iff (!rstN)
    (globalMask && (flags != '0) && (strobe.statusWr == 1'b0) && !strobe.dataAccess)
      |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/irqFlagUnit.sv
module irqFlagUnit
  import irqFlagPkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [FLAG_W-1:0] hwEvent,
  input  logic              globalMask,
  output logic              irq
);
  regStrobe_t strobe;

  irqFlagBusCtrl uCtrl (
    .busRd   (busRd),
    .busWr   (busWr),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  irqFlagDatapath #(.FLAG_W(FLAG_W), .DATA_W(DATA_W)) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .wdata      (busWdata),
    .hwEvent    (hwEvent),
    .globalMask (globalMask),
    .rdata      (busRdata),
    .irq        (irq)
  );

  p_idle_read_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |-> (busRdata == '0));
endmodule

// File: tb/tb_irqFlagUnit.sv
module tb_irqFlagUnit;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busRd = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = 2'd0;
  logic [7:0] busWdata = 8'd0;
  logic [7:0] busRdata;
  logic [3:0] hwEvent = 4'd0;
  logic       globalMask = 1'b0;
  logic       irq;

  int passCnt = 0;
  int totalCnt = 0;
  logic [3:0] mFlags = 0, mEn = 0, mArm = 0;
  logic [7:0] mData = 0;
  logic [7:0] lastRd;
  logic       lastIrq, expIrq;

  irqFlagUnit dut (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    totalCnt++;
    if (ok) passCnt++;
    else $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
  endtask

  task automatic step(input logic rd, input logic wr, input logic [1:0] a,
                      input logic [7:0] wd, input logic [3:0] ev);
    logic [3:0] nf;
    @(negedge clk);
    busRd = rd; busWr = wr; busAddr = a; busWdata = wd; hwEvent = ev;
    #1;
    lastRd  = busRdata;
    lastIrq = irq;
    expIrq  = (|(mFlags & mEn)) && !globalMask;
    nf = mFlags;
    if (wr && a == 2'd0) nf = nf & wd[3:0];
    if ((rd || wr) && a == 2'd2) nf = nf & ~mArm;
    nf = nf | ev;
    if ((rd || wr) && a == 2'd2) mArm = 4'd0;
    else if (rd && a == 2'd0) mArm = mFlags;
    if (wr && a == 2'd1) mEn = wd[3:0];
    if (wr && a == 2'd2) mData = wd;
    mFlags = nf;
  endtask

  task automatic idle(input logic [3:0] ev); step(0, 0, 2'd0, 8'd0, ev); endtask
  task automatic rdReg(input logic [1:0] a); step(1, 0, a, 8'd0, 4'd0); endtask
  task automatic wrReg(input logic [1:0] a, input logic [7:0] d); step(0, 1, a, d, 4'd0); endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // R1 reset state
    rdReg(2'd0); chk(lastRd == 8'd0, "R1 status", lastRd, 0);
    chk(lastIrq == 1'b0, "R1 irq", lastIrq, 0);
    rdReg(2'd1); chk(lastRd == 8'd0, "R1 ctrl", lastRd, 0);
    rdReg(2'd2); chk(lastRd == 8'd0, "R1 data", lastRd, 0);

    // R2 R3: every enable x flag pattern under both mask values
    for (int e = 0; e < 16; e++) begin
      wrReg(2'd1, 8'(e));
      for (int f = 0; f < 16; f++) begin
        wrReg(2'd0, 8'd0);
        idle(4'(f));
        for (int m = 0; m < 2; m++) begin
          @(negedge clk); globalMask = m[0];
          rdReg(2'd0);
          chk(lastRd == 8'(f), "R2 status", lastRd, f);
          chk(lastIrq == (((e & f) != 0) && m == 0), "R3 irq", lastIrq,
              ((e & f) != 0) && m == 0);
          chk(lastIrq == expIrq, "R3 model irq", lastIrq, expIrq);
        end
      end
    end
    @(negedge clk); globalMask = 1'b0;

    // R4 pending while disabled, irq on enable
    wrReg(2'd1, 8'd0); wrReg(2'd0, 8'd0); idle(4'h4);
    idle(4'd0); chk(lastIrq == 1'b0, "R4 disabled", lastIrq, 0);
    wrReg(2'd1, 8'h04);
    idle(4'd0); chk(lastIrq == 1'b1, "R4 enabled", lastIrq, 1);

    // R5 write-one no effect, write-zero clears
    for (int f = 0; f < 16; f++) begin
      wrReg(2'd0, 8'd0); idle(4'(f));
      wrReg(2'd0, 8'hFF);
      rdReg(2'd0); chk(lastRd == 8'(f), "R5 write one", lastRd, f);
      wrReg(2'd0, 8'(~f & 8'h0F) | 8'h0A);
      rdReg(2'd0); chk(lastRd == 8'(f & 8'h0A), "R5 write zero", lastRd, f & 8'h0A);
      // R9 event in same cycle as write-zero clear
      step(0, 1, 2'd0, 8'd0, 4'(f));
      rdReg(2'd0); chk(lastRd == 8'(f), "R9 write race", lastRd, f);
    end

    // R6 R7 R9: armed pattern a, later events b, same-cycle event c
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] c;
        logic [3:0] ex;
        c = {b[0], b[3:1]} & 4'(a);
        wrReg(2'd0, 8'd0);
        idle(4'(a));
        rdReg(2'd0);
        idle(4'(b));
        step(b[0], !b[0], 2'd2, 8'(a + b), c);
        rdReg(2'd0);
        ex = (4'(a | b) & ~4'(a)) | c;
        chk(lastRd == 8'(ex), "R6/R7 sequence R9", lastRd, ex);
        chk(lastRd == 8'(mFlags), "R7 model", lastRd, mFlags);
        step(1, 0, 2'd2, 8'd0, 4'd0);
      end
    end

    // R8 masked pending discarded by the sequence
    @(negedge clk); globalMask = 1'b1;
    wrReg(2'd1, 8'h0F); wrReg(2'd0, 8'd0); idle(4'h3);
    rdReg(2'd0); chk(lastIrq == 1'b0, "R8 masked", lastIrq, 0);
    rdReg(2'd2);
    @(negedge clk); globalMask = 1'b0;
    rdReg(2'd0);
    chk(lastRd == 8'd0, "R8 flags lost", lastRd, 0);
    chk(lastIrq == 1'b0, "R8 irq stays low", lastIrq, 0);

    // R10 data access disarms
    idle(4'h1); rdReg(2'd0); rdReg(2'd2);
    idle(4'h2); rdReg(2'd2);
    rdReg(2'd0); chk(lastRd == 8'h02, "R10 disarmed", lastRd, 2);

    // R11 data register, upper status bits zero
    wrReg(2'd2, 8'hA5); rdReg(2'd2); chk(lastRd == 8'hA5, "R11 data A5", lastRd, 8'hA5);
    wrReg(2'd2, 8'h3C); rdReg(2'd2); chk(lastRd == 8'h3C, "R11 data 3C", lastRd, 8'h3C);
    idle(4'hF); rdReg(2'd0); chk(lastRd == 8'h0F, "R2 upper bits", lastRd, 8'h0F);
    rdReg(2'd2); chk(lastRd == mData, "R11 data keep", lastRd, mData);

    idle(4'd0);
    $display("%0d/%0d checks passed", passCnt, totalCnt);
    $finish;
  end
endmodule